// File: doc/BRIEF.md
# Boot-Time Debug Lock Controller

This block orders the early part of a chip's power-up and decides whether the serial-wire debug port may be opened. Once reset is released it waits a fixed settling interval while supplies and clocks stabilise. It then fetches a single protection word from the non-volatile configuration area over a plain request/valid read port and registers that word. After a one-cycle decision stage it drives the debug-enable line to the debug access port and raises a boot-complete flag.

The port opens only when the fetched word is exactly the erased pattern of all ones. Every other value fails secure and keeps the port shut. This covers the programmed lock value of all zeros and any corrupted read. If the memory never answers within the timeout window, boot still completes, an error flag is raised and the port stays shut. A software lock input can shut the port at any time. It holds that state until the next reset.

Top module: `boot_dbg_lock`

## Requirements
- R1: While reset is asserted, `dbg_enable`, `boot_done`, `cfg_rd_req` and `cfg_error` are all low.
- R2: `cfg_rd_req` is first seen high exactly SETTLE_CYCLES (default 64) clock edges after reset is released, with `cfg_rd_addr` equal to PROT_ADDR (default 0x208).
- R3: `cfg_rd_req` stays high until `cfg_rd_valid` is sampled high with it. The word on `cfg_rd_data` is captured at that edge and `cfg_rd_req` is low one cycle later.
- R4: `boot_done` rises one cycle after `cfg_rd_req` falls. It then stays high until reset.
- R5: After boot, `dbg_enable` is high only if the captured word is exactly 0xFF (all ones), no lock request was seen and no timeout occurred.
- R6: Any captured word other than 0xFF leaves `dbg_enable` low. This includes the lock code 0x00 and every corrupted value.
- R7: `dbg_enable` is low in every cycle before `boot_done` rises, whatever the protection word.
- R8: If `cfg_rd_valid` is not seen within RD_TIMEOUT (default 256) cycles of the request, `cfg_rd_req` drops after exactly 256 cycles and `cfg_error` goes high and stays high until reset. Boot then completes with `dbg_enable` low.
- R9: `sw_lock_req` sampled high forces `dbg_enable` low from the next cycle until reset, whether it comes before or after boot. Dropping the request later has no effect.
- R10: `cfg_rd_valid` pulses while no read is requested are ignored. Stray pulses carrying 0x00 during the settling interval do not stop a later 0xFF read from opening the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_lock_req | input | 1 | Software request to shut the debug port until reset |
| cfg_rd_valid | input | 1 | Read data valid from configuration memory |
| cfg_rd_data | input | WORD_W | Read data from configuration memory |
| cfg_rd_req | output | 1 | Read request to configuration memory |
| cfg_rd_addr | output | ADDR_W | Address of the protection word |
| dbg_enable | output | 1 | Debug port enable to the debug access port |
| boot_done | output | 1 | Boot sequence finished |
| cfg_error | output | 1 | Protection word read timed out |

## Verification
The protection fetch is tried with all 256 word values and varied read latencies. This separates the single opening code from every value that must fail secure, and shows that the port is never enabled before boot completes, whatever the word. A latency equal to the last allowed cycle is contrasted with a memory that never answers. This tells a late but valid answer apart from a timeout. Stray valid pulses during settling are mixed into the sweep, and software lock requests are placed both before and after boot. Together these show that unrequested data is ignored and that a lock stays shut once set.

// File: rtl/bdl_pkg.sv
package bdl_pkg;
   typedef enum logic [1:0] {
      PH_SETTLE = 2'd0,
      PH_FETCH  = 2'd1,
      PH_DECIDE = 2'd2,
      PH_READY  = 2'd3
   } boot_phase_t;
endpackage

// File: rtl/bdl_cycle_timer.sv
module bdl_cycle_timer #(
   parameter int LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic hit
);
   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   assign hit = en && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr)    cnt_q <= '0;
      else if (en)     cnt_q <= cnt_q + CW'(1);
   end
endmodule

// File: rtl/bdl_seq.sv
module bdl_seq
   import bdl_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        settle_hit,
   input  logic        fetch_ok,
   input  logic        fetch_expire,
   output boot_phase_t phase
);
   boot_phase_t phase_d;

   always_comb begin
      phase_d = phase;
      unique case (phase)
         PH_SETTLE: if (settle_hit)               phase_d = PH_FETCH;
         PH_FETCH:  if (fetch_ok || fetch_expire) phase_d = PH_DECIDE;
         PH_DECIDE:                               phase_d = PH_READY;
         PH_READY:                                phase_d = PH_READY;
         default:                                 phase_d = PH_SETTLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_SETTLE;
      else        phase <= phase_d;
   end
endmodule

// File: rtl/bdl_gate.sv
module bdl_gate
   import bdl_pkg::*;
#(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  boot_phase_t       phase,
   input  logic              fetch_ok,
   input  logic              fetch_expire,
   input  logic [WORD_W-1:0] rd_word,
   input  logic              sw_lock_req,
   output logic              dbg_enable,
   output logic              err_flag
);
   localparam logic [WORD_W-1:0] OPEN_CODE   = '1;
   localparam logic [WORD_W-1:0] LOCKED_INIT = '0;

   logic [WORD_W-1:0] word_q;
   logic              open_q;
   logic              lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q   <= LOCKED_INIT;
         err_flag <= 1'b0;
         open_q   <= 1'b0;
         lock_q   <= 1'b0;
      end else begin
         if (fetch_ok)
            word_q <= rd_word;
         if (fetch_expire && !fetch_ok)
            err_flag <= 1'b1;
         if (phase == PH_DECIDE)
            open_q <= (word_q == OPEN_CODE) && !err_flag;
         if (sw_lock_req)
            lock_q <= 1'b1;
      end
   end

   assign dbg_enable = open_q && !lock_q;
endmodule

// File: rtl/boot_dbg_lock.sv
module boot_dbg_lock
   import bdl_pkg::*;
#(
   parameter int                WORD_W        = 8,
   parameter int                ADDR_W        = 12,
   parameter logic [ADDR_W-1:0] PROT_ADDR     = 12'h208,
   parameter int                SETTLE_CYCLES = 64,
   parameter int                RD_TIMEOUT    = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_lock_req,
   input  logic              cfg_rd_valid,
   input  logic [WORD_W-1:0] cfg_rd_data,
   output logic              cfg_rd_req,
   output logic [ADDR_W-1:0] cfg_rd_addr,
   output logic              dbg_enable,
   output logic              boot_done,
   output logic              cfg_error
);
   generate
      if (WORD_W < 1)        begin : g_bad_word   $error("WORD_W must be at least 1");        end
      if (ADDR_W < 1)        begin : g_bad_addr   $error("ADDR_W must be at least 1");        end
      if (SETTLE_CYCLES < 1) begin : g_bad_settle $error("SETTLE_CYCLES must be at least 1"); end
      if (RD_TIMEOUT < 0)    begin : g_bad_tmo    $error("RD_TIMEOUT must not be negative");  end
   endgenerate

   boot_phase_t phase;
   logic        settle_hit;
   logic        fetch_ok;
   logic        fetch_expire;
   logic        in_settle;
   logic        in_fetch;

   assign in_settle   = (phase == PH_SETTLE);
   assign in_fetch    = (phase == PH_FETCH);
   assign fetch_ok    = in_fetch && cfg_rd_valid;
   assign cfg_rd_req  = in_fetch;
   assign cfg_rd_addr = PROT_ADDR;
   assign boot_done   = (phase == PH_READY);

   bdl_cycle_timer #(.LIMIT(SETTLE_CYCLES)) u_settle_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!in_settle),
      .en    (in_settle),
      .hit   (settle_hit)
   );

   generate
      if (RD_TIMEOUT > 0) begin : g_timeout
         bdl_cycle_timer #(.LIMIT(RD_TIMEOUT)) u_fetch_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (!in_fetch),
            .en    (in_fetch && !cfg_rd_valid),
            .hit   (fetch_expire)
         );
      end else begin : g_wait_forever
         assign fetch_expire = 1'b0;
      end
   endgenerate

   bdl_seq u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .settle_hit   (settle_hit),
      .fetch_ok     (fetch_ok),
      .fetch_expire (fetch_expire),
      .phase        (phase)
   );

   bdl_gate #(.WORD_W(WORD_W)) u_gate (
      .clk          (clk),
      .rst_n        (rst_n),
      .phase        (phase),
      .fetch_ok     (fetch_ok),
      .fetch_expire (fetch_expire),
      .rd_word      (cfg_rd_data),
      .sw_lock_req  (sw_lock_req),
      .dbg_enable   (dbg_enable),
      .err_flag     (cfg_error)
   );
endmodule

// File: rtl/bdl_chk.sv
module bdl_chk (
   input logic clk,
   input logic rst_n,
   input logic sw_lock_req,
   input logic cfg_rd_valid,
   input logic cfg_rd_req,
   input logic dbg_enable,
   input logic boot_done,
   input logic cfg_error
);
   // R7
   open_only_after_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_enable |-> boot_done);

   // R3
   req_drops_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd_req && cfg_rd_valid) |=> !cfg_rd_req);

   // R4
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      boot_done |=> boot_done);

   // R4
   done_excludes_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(boot_done && cfg_rd_req));

   // R8
   error_keeps_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_error |-> !dbg_enable);

   // R8
   error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_error |=> cfg_error);

   // R9
   lock_request_shuts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_lock_req |=> !dbg_enable);

   // R9
   no_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_done && !dbg_enable) |=> !dbg_enable);
endmodule

bind boot_dbg_lock bdl_chk u_bdl_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sw_lock_req  (sw_lock_req),
   .cfg_rd_valid (cfg_rd_valid),
   .cfg_rd_req   (cfg_rd_req),
   .dbg_enable   (dbg_enable),
   .boot_done    (boot_done),
   .cfg_error    (cfg_error)
);

// File: tb/boot_dbg_lock_bench.sv
module boot_dbg_lock_bench;
   localparam int SETTLE  = 64;
   localparam int TIMEOUT = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_lock_req = 1'b0;
   logic        cfg_rd_valid;
   logic [7:0]  cfg_rd_data;
   logic        cfg_rd_req;
   logic [11:0] cfg_rd_addr;
   logic        dbg_enable;
   logic        boot_done;
   logic        cfg_error;

   int compared = 0;
   int mismatched = 0;

   logic [7:0] mem_word = 8'h00;
   int         mem_lat = 0;
   bit         mem_silent = 1'b0;
   bit         mem_stray = 1'b0;
   int         wait_cnt;
   bit         prev_done;

   logic [1:0] exp_q[$];

   always #4 clk = ~clk;

   boot_dbg_lock u_boot_dbg_lock (
      .clk          (clk),
      .rst_n        (rst_n),
      .sw_lock_req  (sw_lock_req),
      .cfg_rd_valid (cfg_rd_valid),
      .cfg_rd_data  (cfg_rd_data),
      .cfg_rd_req   (cfg_rd_req),
      .cfg_rd_addr  (cfg_rd_addr),
      .dbg_enable   (dbg_enable),
      .boot_done    (boot_done),
      .cfg_error    (cfg_error)
   );

   // configuration memory model
   always @(negedge clk) begin
      if (!rst_n) begin
         cfg_rd_valid <= 1'b0;
         cfg_rd_data  <= 8'h00;
         wait_cnt     <= 0;
      end else if (cfg_rd_req) begin
         if (!mem_silent && wait_cnt == mem_lat) begin
            cfg_rd_valid <= 1'b1;
            cfg_rd_data  <= mem_word;
         end else begin
            cfg_rd_valid <= 1'b0;
            wait_cnt     <= wait_cnt + 1;
         end
      end else begin
         wait_cnt     <= 0;
         cfg_rd_valid <= mem_stray && !boot_done;
         cfg_rd_data  <= 8'h00;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: compares result at the first boot_done cycle
   always @(negedge clk) begin
      if (!rst_n) prev_done <= 1'b0;
      else begin
         prev_done <= boot_done;
         if (boot_done && !prev_done) begin
            if (exp_q.size() == 0) chk(1'b0, "R5 R6 empty queue", 0, 1);
            else begin
               logic [1:0] e;
               e = exp_q.pop_front();
               // R5 R6 R8 R10: final open state and error flag
               chk({dbg_enable, cfg_error} == e, "R5 R6 R8 R10 outcome",
                   {dbg_enable, cfg_error}, e);
            end
         end
      end
   end

   task automatic run_boot(input logic [7:0] w, input int lat, input bit silent,
                           input bit stray, input bit lock_early, input bit lock_late);
      int  n;
      bit  leak;
      @(negedge clk);
      rst_n = 1'b0;
      sw_lock_req = 1'b0;
      mem_word = w; mem_lat = lat; mem_silent = silent; mem_stray = stray;
      repeat (2) @(negedge clk);
      // R1
      chk({dbg_enable, boot_done, cfg_rd_req, cfg_error} == 4'b0, "R1 reset state",
          {dbg_enable, boot_done, cfg_rd_req, cfg_error}, 0);
      exp_q.push_back({(w == 8'hFF) && !silent && !lock_early, silent});
      rst_n = 1'b1;
      if (lock_early) sw_lock_req = 1'b1;
      n = 0; leak = 1'b0;
      while (!cfg_rd_req && n < 1000) begin
         @(negedge clk);
         n++;
         sw_lock_req = 1'b0;
         if (dbg_enable || boot_done) leak = 1'b1;
      end
      // R2
      chk(n == SETTLE, "R2 settle length", n, SETTLE);
      chk(cfg_rd_addr == 12'h208, "R2 address", cfg_rd_addr, 12'h208);
      n = 0;
      while (cfg_rd_req && n < 1000) begin
         @(negedge clk);
         n++;
         if (dbg_enable || boot_done) leak = 1'b1;
      end
      if (silent) chk(n == TIMEOUT, "R8 timeout length", n, TIMEOUT);
      else        chk(n == lat + 1, "R3 request held until valid", n, lat + 1);
      // R4 R7: decision cycle still closed
      chk(!boot_done && !dbg_enable, "R4 R7 decide cycle", {boot_done, dbg_enable}, 0);
      // R7
      chk(!leak, "R7 no early enable", leak, 0);
      @(negedge clk);
      chk(boot_done, "R4 done timing", boot_done, 1);
      if (lock_late) begin
         sw_lock_req = 1'b1;
         @(negedge clk);
         sw_lock_req = 1'b0;
         // R9
         chk(!dbg_enable, "R9 late lock", dbg_enable, 0);
      end
      repeat (3) @(negedge clk);
      // R4 R8 R9: sticky state
      chk(boot_done && cfg_error == silent && !(lock_late && dbg_enable),
          "R4 R8 R9 sticky", {boot_done, cfg_error, dbg_enable}, {1'b1, silent, 1'b0});
   endtask

   initial begin
      run_boot(8'hFF, 0,   0, 0, 0, 1);   // R5 R9 open then late lock
      run_boot(8'hFF, 255, 0, 0, 0, 0);   // R3 R8 last allowed cycle
      run_boot(8'hFF, 2,   0, 1, 0, 0);   // R10 stray pulses ignored
      run_boot(8'hFF, 1,   0, 0, 1, 0);   // R9 lock before boot
      run_boot(8'hFF, 0,   1, 0, 0, 0);   // R8 silent memory
      run_boot(8'h00, 3,   0, 0, 0, 0);   // R6 lock code
      for (int v = 0; v < 256; v++)
         run_boot(8'(v), v % 4, 1'b0, (v % 3) == 0, 1'b0, 1'b0);  // R6 R7 sweep
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R5 queue drained", exp_q.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      compared++;
      mismatched++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule